// File: doc/BRIEF.md
# Bit set, clear and test-with-skip unit

This unit carries out the single-bit register operations of a small 8-bit controller core. In the execute cycle of an instruction the sequencer presents the 14-bit instruction word together with the byte already read from the addressed register. For a set or clear, the unit returns that byte with one chosen bit forced, plus the register address and a write enable. For a bit test, it raises a skip request when the tested bit matches the condition in the instruction. The sequencer then throws away the instruction it fetched next and runs an empty cycle in its place, so a taken test costs two instruction cycles and an untaken one costs one.

The outputs are registered. Everything the unit decides from the inputs of one cycle appears on its outputs in the following cycle. The write enable and the skip request are each high for exactly that one cycle. The sequencer holds an inhibit input high during the empty cycle that follows a skip, so that the discarded slot can neither write nor skip. Instructions outside the bit-operation group pass through with no effect.

Top module: `bitop_unit`

## Requirements
- R1: While reset (rst_n low) is applied and in the first cycle after it, wr_en and skip are 0, and wr_data and wr_addr are 0.
- R2: An instruction whose bits 13:12 are 01 and bits 11:10 are 00, presented with exec_en=1 and nop_cycle=0, clears bit number instr[9:7] of rd_data. In the next cycle wr_en=1, wr_data is rd_data with that one bit at 0 and all other bits unchanged, and wr_addr=instr[6:0]. Example: clearing bit 7 of 0xC7 gives 0x47.
- R3: Under the same conditions, bits 11:10 = 01 sets bit instr[9:7]. In the next cycle wr_en=1, wr_data is rd_data with that bit at 1 and all other bits unchanged, and wr_addr=instr[6:0]. Example: setting bit 7 of 0x0A gives 0x8A.
- R4: Bits 11:10 = 10 tests the bit and requests a skip when it is 0. In the next cycle skip=1 if rd_data[instr[9:7]] is 0 and skip=0 if it is 1. wr_en stays 0.
- R5: Bits 11:10 = 11 tests the bit and requests a skip when it is 1. In the next cycle skip=1 if rd_data[instr[9:7]] is 1 and skip=0 if it is 0. wr_en stays 0.
- R6: wr_en and skip are single-cycle pulses. A cycle with no qualifying instruction leaves both at 0 in the following cycle, and the two are never 1 together.
- R7: With nop_cycle=1, no write and no skip result in the next cycle, whatever the instruction, and wr_data and wr_addr keep their previous values.
- R8: With exec_en=0, no write and no skip result in the next cycle, and wr_data and wr_addr keep their previous values.
- R9: With exec_en=1, an instruction whose bits 13:12 are not 01 leaves wr_en and skip at 0 in the next cycle, and wr_data and wr_addr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Instruction is in its execute cycle |
| nop_cycle | input | 1 | Forced empty cycle; suppresses write and skip |
| instr | input | 14 | Instruction word |
| rd_data | input | 8 | Byte read from the addressed register |
| wr_addr | output | 7 | Register address for write-back |
| wr_data | output | 8 | Modified byte for write-back |
| wr_en | output | 1 | Write-back enable pulse |
| skip | output | 1 | Request to discard the next instruction |

## Verification
The hardest case to produce is a qualifying bit instruction that arrives at the same time as the inhibit. Here the unit must ignore an instruction that would otherwise write or skip, and the evidence is only that the held write data stays unchanged. The stimulus first makes a known write, then offers set, clear and both test forms with nop_cycle high and data chosen so that each would act. Random cycles then mix inhibit, idle and foreign instruction classes with back-to-back operations, so that pulses adjacent to suppressed cycles are checked as well.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int INSTR_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_en,
  input  logic               nop_cycle,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_en,
  output logic               skip
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int OP_LSB  = ADDR_W + BIT_W;
  localparam int CLS_LSB = OP_LSB + 2;

  logic [1:0]        cls, op;
  logic [BIT_W-1:0]  bsel;
  logic [DATA_W-1:0] mask, modified;
  logic              live, picked, do_wr, do_skip;

  assign cls  = instr[CLS_LSB +: 2];
  assign op   = instr[OP_LSB +: 2];
  assign bsel = instr[ADDR_W +: BIT_W];
  assign mask = {{(DATA_W-1){1'b0}}, 1'b1} << bsel;

  assign live     = exec_en && !nop_cycle && (cls == 2'b01);
  assign picked   = rd_data[bsel];
  assign modified = op[0] ? (rd_data | mask) : (rd_data & ~mask);
  assign do_wr    = live && !op[1];
  assign do_skip  = live && op[1] && (picked == op[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      skip    <= 1'b0;
      wr_data <= '0;
      wr_addr <= '0;
    end else begin
      wr_en <= do_wr;
      skip  <= do_skip;
      if (do_wr) begin
        wr_data <= modified;
        wr_addr <= instr[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int INSTR_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exec_en,
  input logic               nop_cycle,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  rd_data,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               wr_en,
  input logic               skip
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int OP_LSB  = ADDR_W + BIT_W;
  localparam int CLS_LSB = OP_LSB + 2;

  logic [BIT_W-1:0]  b;
  logic [1:0]        o;
  logic              q;
  logic [DATA_W-1:0] m;

  assign b = instr[ADDR_W +: BIT_W];
  assign o = instr[OP_LSB +: 2];
  assign q = exec_en && !nop_cycle && (instr[CLS_LSB +: 2] == 2'b01);
  assign m = {{(DATA_W-1){1'b0}}, 1'b1} << b;

  p_clear_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q && o == 2'b00 |=> wr_en && !skip && wr_data[$past(b)] == 1'b0 && wr_addr == $past(instr[ADDR_W-1:0]));
  p_set_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q && o == 2'b01 |=> wr_en && !skip && wr_data[$past(b)] == 1'b1 && wr_addr == $past(instr[ADDR_W-1:0]));
  p_others_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q && !o[1] |=> ((wr_data ^ $past(rd_data)) & ~$past(m)) == '0);
  p_skip_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q && o == 2'b10 |=> !wr_en && (skip == !$past(rd_data[b])));
  p_skip_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q && o == 2'b11 |=> !wr_en && (skip == $past(rd_data[b])));
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && skip));
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nop_cycle |=> !wr_en && !skip && $stable(wr_data) && $stable(wr_addr));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> !wr_en && !skip && $stable(wr_data));
  p_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && instr[CLS_LSB +: 2] != 2'b01 |=> !wr_en && !skip && $stable(wr_data));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .nop_cycle(nop_cycle), .instr(instr),
  .rd_data(rd_data), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .skip(skip));

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic        nop_cycle = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  rd_data = '0;
  logic [6:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        wr_en, skip;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_data = '0;
  logic [6:0] m_addr = '0;

  always #10 clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .nop_cycle(nop_cycle), .instr(instr),
    .rd_data(rd_data), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .skip(skip));

  function automatic logic [13:0] mk(input logic [1:0] c, input logic [1:0] o,
                                     input logic [2:0] b, input logic [6:0] a);
    return {c, o, b, a};
  endfunction

  task automatic check(input string req, input logic [7:0] e_data, input logic [6:0] e_addr,
                       input logic e_wr, input logic e_sk);
    checks++;
    if (wr_data !== e_data || wr_addr !== e_addr || wr_en !== e_wr || skip !== e_sk) begin
      failures++;
      $display("FAIL %s: got data=%h addr=%h wr=%b skip=%b, expected data=%h addr=%h wr=%b skip=%b",
               req, wr_data, wr_addr, wr_en, skip, e_data, e_addr, e_wr, e_sk);
    end
  endtask

  task automatic run(input string req, input logic ex, input logic np,
                     input logic [13:0] ins, input logic [7:0] rd);
    logic ew, es, bitv;
    logic [2:0] b;
    @(negedge clk);
    exec_en = ex; nop_cycle = np; instr = ins; rd_data = rd;
    b = ins[9:7];
    bitv = rd[b];
    ew = 1'b0; es = 1'b0;
    if (ex && !np && ins[13:12] == 2'b01) begin
      case (ins[11:10])
        2'b00: begin ew = 1'b1; m_data = rd & ~(8'h01 << b); m_addr = ins[6:0]; end
        2'b01: begin ew = 1'b1; m_data = rd | (8'h01 << b); m_addr = ins[6:0]; end
        2'b10: es = !bitv;
        default: es = bitv;
      endcase
    end
    @(posedge clk);
    #5;
    check(req, m_data, m_addr, ew, es);
  endtask

  initial begin
    #(20.0 * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b17));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", 8'h00, 7'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1 after reset", 8'h00, 7'h00, 1'b0, 1'b0);

    run("R3 set bit7 of 0x0A", 1, 0, mk(2'b01, 2'b01, 3'd7, 7'h0C), 8'h0A);
    if (wr_data !== 8'h8A) begin failures++; $display("FAIL R3: got %h expected 8a", wr_data); end
    checks++;
    run("R2 clear bit7 of 0xC7", 1, 0, mk(2'b01, 2'b00, 3'd7, 7'h21), 8'hC7);
    if (wr_data !== 8'h47) begin failures++; $display("FAIL R2: got %h expected 47", wr_data); end
    checks++;
    run("R6 pulse ends", 0, 0, mk(2'b01, 2'b01, 3'd0, 7'h01), 8'h00);
    run("R2 clear bit0", 1, 0, mk(2'b01, 2'b00, 3'd0, 7'h7F), 8'hFF);
    run("R3 set bit0", 1, 0, mk(2'b01, 2'b01, 3'd0, 7'h00), 8'h00);
    run("R4 test-clear bit zero skips", 1, 0, mk(2'b01, 2'b10, 3'd1, 7'h05), 8'hFD);
    run("R6 skip pulse ends", 0, 0, mk(2'b01, 2'b10, 3'd1, 7'h05), 8'h00);
    run("R4 test-clear bit one no skip", 1, 0, mk(2'b01, 2'b10, 3'd1, 7'h05), 8'h02);
    run("R5 test-set bit one skips", 1, 0, mk(2'b01, 2'b11, 3'd6, 7'h09), 8'h40);
    run("R5 test-set bit zero no skip", 1, 0, mk(2'b01, 2'b11, 3'd6, 7'h09), 8'hBF);
    run("R7 inhibit set", 1, 1, mk(2'b01, 2'b01, 3'd2, 7'h33), 8'h00);
    run("R7 inhibit clear", 1, 1, mk(2'b01, 2'b00, 3'd2, 7'h33), 8'hFF);
    run("R7 inhibit test-clear", 1, 1, mk(2'b01, 2'b10, 3'd2, 7'h33), 8'h00);
    run("R7 inhibit test-set", 1, 1, mk(2'b01, 2'b11, 3'd2, 7'h33), 8'hFF);
    run("R8 idle set", 0, 0, mk(2'b01, 2'b01, 3'd4, 7'h44), 8'h00);
    run("R9 class 00", 1, 0, mk(2'b00, 2'b01, 3'd4, 7'h44), 8'h00);
    run("R9 class 10", 1, 0, mk(2'b10, 2'b00, 3'd4, 7'h44), 8'hFF);
    run("R9 class 11", 1, 0, mk(2'b11, 2'b11, 3'd4, 7'h44), 8'hFF);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      logic ex, np;
      c  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b01;
      ex = ($urandom % 6) != 0;
      np = ($urandom % 5) == 0;
      run(!ex ? "R8 random" : np ? "R7 random" : (c != 2'b01) ? "R9 random" : "R6 random op",
          ex, np, mk(c, 2'($urandom), 3'($urandom), 7'($urandom)), 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule